// File: doc/BRIEF.md
# Bit-Split Automaton String Matcher

This block scans a byte stream for a set of mapped patterns using several identical finite-state tiles. Each tile runs its own deterministic automaton over a two-bit symbol drawn from every input byte. One symbol bit comes from the high end of the byte and one from the low end. Between them, the tiles cover the whole byte. Failure transitions are already folded into each tile's next-state table, so every accepted byte moves each tile by exactly one transition, and a new byte can be taken on every cycle.

Each state holds only a short match index. The index selects a row of a small per-tile match-vector table, so states that share a vector share one row. The vectors of all tiles are combined by bitwise AND into the full match vector. Bit i of that vector is set when pattern i ended on the byte just accepted. All tables are writable registers loaded through a configuration port. A separate pattern compiler supplies their contents.

Top module: `bsm_matcher`

## Requirements
- R1: Reset clears matchValid and matchVec to zero, puts every tile in state 0 and clears all table contents to zero; the first accepted byte after reset is looked up from state 0.
- R2: With a byte width of 8 and four tiles, tile t takes the symbol {inByte[7-t], inByte[t]}, with the high-end bit as symbol bit 1.
- R3: Each tile's next-state table has 2^2 entries per state, at address state*4 + symbol; an accepted byte moves each tile to the entry for its current state and symbol.
- R4: Each state owns an index into a per-tile match-vector table of MV_W/2 entries (4 for the default width of 8); a tile's partial vector is the table row selected by the index of the state it moves to.
- R5: matchVec is the bitwise AND of the partial vectors of all tiles.
- R6: An accepted byte (inValid high at a clock edge) sets matchValid to 1 and matchVec to the combined vector of the states just entered, both at that same edge.
- R7: While inValid is low, every tile keeps its state, and at the next edge matchValid and matchVec become zero.
- R8: A configuration write (cfgWe high) becomes visible from the next edge on; a byte accepted at the same edge still uses the old contents.
- R9: cfgSel selects the table written: 0 next-state (data bits [3:0] at cfgAddr), 1 state index (data bits [1:0] at state cfgAddr[3:0]), 2 match vector (all data bits at row cfgAddr[1:0]), 3 no table. A write with cfgSel 3 changes no table.
- R10: Bytes accepted on back-to-back cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | inByte carries a byte to accept |
| inByte | input | BYTE_W (8) | Stream byte |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Table select: 0 next-state, 1 index, 2 vector, 3 none |
| cfgTile | input | TILE_SEL_W (2) | Tile written |
| cfgAddr | input | NS_ADDR_W (6) | Table address |
| cfgData | input | MV_W (8) | Write data |
| matchValid | output | 1 | A byte was accepted at the last edge |
| matchVec | output | MV_W (8) | Patterns that ended on that byte |

## Verification
The hardest case to reach from the ports is a write that lands on the very entry that a byte consumed at the same edge is reading. The table must give the old value to that byte and the new value to the next byte. The stimulus loads all tables, feeds random bytes, and mixes in random writes. The directed steps go further: they write the next-state entry for a tile's current state and a chosen symbol in the same cycle as the byte that uses it. Each tile's own state is tracked so that this entry can be found. The match vectors are loaded densely, so the four-way AND still leaves bits set and the result shows what each tile saw.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int TILE_BITS = 2;

  typedef enum logic [1:0] {
    CFG_NEXT   = 2'd0,
    CFG_INDEX  = 2'd1,
    CFG_VECTOR = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic advance;
    logic nsWe;
    logic idxWe;
    logic mvWe;
  } strobe_t;
endpackage

// File: rtl/bsm_control.sv
module bsm_control #(
  parameter int NUM_TILES  = 4,
  parameter int TILE_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  cfgWe,
  input  logic [1:0]            cfgSel,
  input  logic [TILE_SEL_W-1:0] cfgTile,
  output bsm_pkg::strobe_t      strb,
  output logic [NUM_TILES-1:0]  tileSel
);
  import bsm_pkg::*;

  always_comb begin
    strb.advance = inValid;
    strb.nsWe    = cfgWe && (cfg_sel_e'(cfgSel) == CFG_NEXT);
    strb.idxWe   = cfgWe && (cfg_sel_e'(cfgSel) == CFG_INDEX);
    strb.mvWe    = cfgWe && (cfg_sel_e'(cfgSel) == CFG_VECTOR);
  end

  always_comb begin
    tileSel = '0;
    for (int t = 0; t < NUM_TILES; t++) begin
      if (cfgWe && (int'(cfgTile) == t)) tileSel[t] = 1'b1;
    end
  end

  AST_TILE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tileSel)) else $error("tile select not one-hot"); // R9
  AST_RESERVED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSel == 2'd3) |-> !(strb.nsWe || strb.idxWe || strb.mvWe)) else $error("reserved select wrote"); // R9
endmodule

// File: rtl/bsm_tile.sv
module bsm_tile #(
  parameter int STATE_W   = 4,
  parameter int MV_W      = 8,
  parameter int NS_ADDR_W = STATE_W + 2,
  localparam int NUM_STATES = 1 << STATE_W,
  localparam int NS_DEPTH   = NUM_STATES << bsm_pkg::TILE_BITS,
  localparam int MV_ENTRIES = MV_W / 2,
  localparam int IDX_W      = (MV_ENTRIES > 1) ? $clog2(MV_ENTRIES) : 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            advance,
  input  logic                            nsWe,
  input  logic                            idxWe,
  input  logic                            mvWe,
  input  logic [NS_ADDR_W-1:0]            cfgAddr,
  input  logic [MV_W-1:0]                 cfgData,
  input  logic [bsm_pkg::TILE_BITS-1:0]   sym,
  output logic [MV_W-1:0]                 pmvNext
);
  logic [STATE_W-1:0] state;
  logic [STATE_W-1:0] nextState;
  logic [STATE_W-1:0] nsTab  [NS_DEPTH];
  logic [IDX_W-1:0]   idxTab [NUM_STATES];
  logic [MV_W-1:0]    mvTab  [MV_ENTRIES];

  assign nextState = nsTab[{state, sym}];
  assign pmvNext   = mvTab[idxTab[nextState]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= '0;
    end else if (advance) begin
      state <= nextState;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NS_DEPTH; i++) nsTab[i] <= '0;
    end else if (nsWe) begin
      nsTab[cfgAddr] <= cfgData[STATE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_STATES; i++) idxTab[i] <= '0;
    end else if (idxWe) begin
      idxTab[cfgAddr[STATE_W-1:0]] <= cfgData[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MV_ENTRIES; i++) mvTab[i] <= '0;
    end else if (mvWe) begin
      mvTab[cfgAddr[IDX_W-1:0]] <= cfgData;
    end
  end

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(state)) else $error("state moved while idle"); // R7
endmodule

// File: rtl/bsm_datapath.sv
module bsm_datapath #(
  parameter int BYTE_W    = 8,
  parameter int NUM_TILES = 4,
  parameter int STATE_W   = 4,
  parameter int MV_W      = 8,
  parameter int NS_ADDR_W = STATE_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bsm_pkg::strobe_t     strb,
  input  logic [NUM_TILES-1:0] tileSel,
  input  logic [BYTE_W-1:0]    inByte,
  input  logic [NS_ADDR_W-1:0] cfgAddr,
  input  logic [MV_W-1:0]      cfgData,
  output logic                 matchValid,
  output logic [MV_W-1:0]      matchVec
);
  logic [MV_W-1:0] pmv [NUM_TILES];
  logic [MV_W-1:0] fullNext;

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    logic [bsm_pkg::TILE_BITS-1:0] sym;
    assign sym = {inByte[BYTE_W-1-t], inByte[t]};

    bsm_tile #(
      .STATE_W   (STATE_W),
      .MV_W      (MV_W),
      .NS_ADDR_W (NS_ADDR_W)
    ) u_tile (
      .clk     (clk),
      .rstN    (rstN),
      .advance (strb.advance),
      .nsWe    (strb.nsWe  && tileSel[t]),
      .idxWe   (strb.idxWe && tileSel[t]),
      .mvWe    (strb.mvWe  && tileSel[t]),
      .cfgAddr (cfgAddr),
      .cfgData (cfgData),
      .sym     (sym),
      .pmvNext (pmv[t])
    );
  end

  always_comb begin
    fullNext = '1;
    for (int t = 0; t < NUM_TILES; t++) fullNext &= pmv[t];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchValid <= 1'b0;
      matchVec   <= '0;
    end else begin
      matchValid <= strb.advance;
      matchVec   <= strb.advance ? fullNext : '0;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> (matchVec == '0)) else $error("vector set while idle"); // R7
  AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (matchVec != '0) |-> matchValid) else $error("vector without valid"); // R6
endmodule

// File: rtl/bsm_matcher.sv
module bsm_matcher #(
  parameter int BYTE_W  = 8,
  parameter int STATE_W = 4,
  parameter int MV_W    = 8,
  localparam int NUM_TILES  = BYTE_W / bsm_pkg::TILE_BITS,
  localparam int TILE_SEL_W = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1,
  localparam int NS_ADDR_W  = STATE_W + bsm_pkg::TILE_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [BYTE_W-1:0]     inByte,
  input  logic                  cfgWe,
  input  logic [1:0]            cfgSel,
  input  logic [TILE_SEL_W-1:0] cfgTile,
  input  logic [NS_ADDR_W-1:0]  cfgAddr,
  input  logic [MV_W-1:0]       cfgData,
  output logic                  matchValid,
  output logic [MV_W-1:0]       matchVec
);
  bsm_pkg::strobe_t     strb;
  logic [NUM_TILES-1:0] tileSel;

  bsm_control #(
    .NUM_TILES  (NUM_TILES),
    .TILE_SEL_W (TILE_SEL_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .cfgWe   (cfgWe),
    .cfgSel  (cfgSel),
    .cfgTile (cfgTile),
    .strb    (strb),
    .tileSel (tileSel)
  );

  bsm_datapath #(
    .BYTE_W    (BYTE_W),
    .NUM_TILES (NUM_TILES),
    .STATE_W   (STATE_W),
    .MV_W      (MV_W),
    .NS_ADDR_W (NS_ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .tileSel    (tileSel),
    .inByte     (inByte),
    .cfgAddr    (cfgAddr),
    .cfgData    (cfgData),
    .matchValid (matchValid),
    .matchVec   (matchVec)
  );
endmodule

// File: tb/bsm_matcher_test.sv
module bsm_matcher_test;
  localparam int NT = 4;
  localparam int NS = 16;
  localparam int NE = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inByte = '0;
  logic       cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [1:0] cfgTile = '0;
  logic [5:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic       matchValid;
  logic [7:0] matchVec;

  int checks = 0;
  int fails  = 0;

  int mNs  [NT][NS*4];
  int mIdx [NT][NS];
  int mMv  [NT][NE];
  int mSt  [NT];

  always #2 clk = ~clk;

  bsm_matcher uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgTile(cfgTile), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .matchValid(matchValid), .matchVec(matchVec)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hang expected completion");
    summary();
  end

  function automatic int symOf(input logic [7:0] b, input int t);
    return int'({b[7-t], b[t]});
  endfunction

  task automatic compare(input logic [7:0] expVec, input logic expV, input string tag);
    checks++;
    if (matchVec !== expVec || matchValid !== expV) begin
      fails++;
      $display("FAIL %s: actual valid=%0b vec=%02h expected valid=%0b vec=%02h",
               tag, matchValid, matchVec, expV, expVec);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] b, input logic we,
                      input logic [1:0] sel, input logic [1:0] tile,
                      input logic [5:0] addr, input logic [7:0] data, input string tag);
    logic [7:0] acc;
    @(negedge clk);
    inValid = v; inByte = b; cfgWe = we; cfgSel = sel;
    cfgTile = tile; cfgAddr = addr; cfgData = data;
    @(posedge clk);
    acc = 8'hFF;
    if (v) begin
      for (int t = 0; t < NT; t++) begin
        int n;
        n = mNs[t][mSt[t]*4 + symOf(b, t)];
        acc &= 8'(mMv[t][mIdx[t][n]]);
        mSt[t] = n;
      end
    end else begin
      acc = 8'h00;
    end
    if (we) begin
      case (sel)
        2'd0: mNs[tile][addr] = int'(data[3:0]);
        2'd1: mIdx[tile][addr[3:0]] = int'(data[1:0]);
        2'd2: mMv[tile][addr[1:0]] = int'(data);
        default: ;
      endcase
    end
    #1;
    compare(acc, v, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int t = 0; t < NT; t++) begin
      mSt[t] = 0;
      for (int i = 0; i < NS*4; i++) mNs[t][i] = 0;
      for (int i = 0; i < NS; i++) mIdx[t][i] = 0;
      for (int i = 0; i < NE; i++) mMv[t][i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    compare(8'h00, 1'b0, "R1 reset outputs");
    @(negedge clk);
    rstN = 1'b1;

    // R1: cleared tables give a zero vector on an accepted byte
    step(1'b1, 8'hA5, 1'b0, 2'd0, 2'd0, 6'd0, 8'd0, "R1 zero tables");

    // load every table (R3 R4 R9)
    for (int t = 0; t < NT; t++) begin
      for (int a = 0; a < NS*4; a++)
        step(1'b0, 8'h00, 1'b1, 2'd0, 2'(t), 6'(a), 8'($urandom), "R3 load next-state");
      for (int s = 0; s < NS; s++)
        step(1'b0, 8'h00, 1'b1, 2'd1, 2'(t), 6'(s), 8'($urandom), "R4 load index");
      for (int e = 0; e < NE; e++)
        step(1'b0, 8'h00, 1'b1, 2'd2, 2'(t), 6'(e),
             8'($urandom | $urandom | $urandom), "R4 load vector");
    end

    // R2: bytes that isolate individual high and low bits
    step(1'b1, 8'h80, 1'b0, 2'd0, 2'd0, 6'd0, 8'd0, "R2 high bit");
    step(1'b1, 8'h01, 1'b0, 2'd0, 2'd0, 6'd0, 8'd0, "R2 low bit");
    step(1'b1, 8'h18, 1'b0, 2'd0, 2'd0, 6'd0, 8'd0, "R2 middle bits");
    step(1'b1, 8'h42, 1'b0, 2'd0, 2'd0, 6'd0, 8'd0, "R2 tile1 pair");

    // R7: idle cycles hold state and clear the output
    step(1'b0, 8'hFF, 1'b0, 2'd0, 2'd0, 6'd0, 8'd0, "R7 idle");
    step(1'b0, 8'h3C, 1'b0, 2'd0, 2'd0, 6'd0, 8'd0, "R7 idle again");
    step(1'b1, 8'h3C, 1'b0, 2'd0, 2'd0, 6'd0, 8'd0, "R7 resume from held state");

    // R8: write the entry a same-cycle byte reads, then use it
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b;
      int t;
      b = 8'($urandom);
      t = k % NT;
      step(1'b1, b, 1'b1, 2'd0, 2'(t), 6'(mSt[t]*4 + symOf(b, t)),
           8'($urandom), "R8 same-cycle write");
      step(1'b1, 8'($urandom), 1'b0, 2'd0, 2'd0, 6'd0, 8'd0, "R8 after write");
    end

    // R9: reserved select leaves all tables untouched
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 8'h00, 1'b1, 2'd3, 2'(k), 6'($urandom), 8'($urandom), "R9 reserved write");
      step(1'b1, 8'($urandom), 1'b0, 2'd0, 2'd0, 6'd0, 8'd0, "R9 after reserved");
    end

    // R10: back-to-back bytes
    for (int k = 0; k < 40; k++)
      step(1'b1, 8'($urandom), 1'b0, 2'd0, 2'd0, 6'd0, 8'd0, "R10 back-to-back");

    // random mix: R3 R4 R5 R6 with occasional writes
    for (int k = 0; k < 4000; k++) begin
      logic v, we;
      logic [1:0] sel;
      logic [7:0] d;
      v   = ($urandom % 4) != 0;
      we  = ($urandom % 8) == 0;
      sel = 2'($urandom);
      d   = (sel == 2'd2) ? 8'($urandom | $urandom | $urandom) : 8'($urandom);
      step(v, 8'($urandom), we, sel, 2'($urandom), 6'($urandom), d, "R5 R6 random");
    end

    summary();
  end
endmodule